// File: doc/BRIEF.md
# Page Program and Erase Sequencer

This block sits behind the serial front-end of a small flash memory and turns the decoded program and erase commands into self-timed internal write cycles. The front-end tells it when a command begins (kind and target address), hands it every completed data byte of a page program, and reports the rising edge of the chip select along with whether that edge fell exactly on a byte boundary with the serial clock low. The sequencer keeps one page of data bytes and a valid bit for each byte. When chip select rises it decides whether to commit the command. A committed command runs a timed busy interval and then writes the memory one byte per clock.

A program ANDs each supplied byte into the stored byte, so a program can only clear bits. An erase sets a sector, a block or the whole array to FFh. The protection logic supplies a lock bit per block, and writes aimed at a locked block are refused. The write-enable latch lives outside the block: it is read on the `wel` input and cleared through the one-cycle `welClear` pulse. The pulse is issued when a cycle completes and also when a command is refused because of protection. Cycle lengths and the array, page, sector and block sizes are all parameters. The defaults keep the array small: 4 KB of memory, 512-byte sectors and 1 KB blocks. Setting SECTOR_W=12 and BLOCK_W=15 gives 4 KB sectors and 32 KB blocks.

Top module: `flash_write_seq`

## Requirements
- R1: After reset `busy` and `welClear` are 0.
- R2: A committed program does mem = mem AND data for every byte supplied during the command. All other bytes of the page stay unchanged. A data byte presented in the same cycle as the chip-select rise is included.
- R3: The page offset starts at cmdAddr[PAGE_W-1:0] and advances by one per byte, wrapping inside the 2**PAGE_W page. When more bytes than the page size arrive, the later bytes replace the earlier ones.
- R4: A command commits only if `csAligned` is 1 at the chip-select rise and, for a program, at least one data byte arrived. Otherwise the command is dropped: the memory is unchanged, `busy` stays 0 and no `welClear` pulse is issued.
- R5: If `wel` is 0 when chip select rises, the command has no effect of any kind.
- R6: cmdKind 1 (sector erase) sets the aligned 2**SECTOR_W-byte region containing cmdAddr to FFh. cmdKind 2 (block erase) does the same for the 2**BLOCK_W-byte region. cmdKind 0 is program.
- R7: cmdKind 3 (chip erase) sets every byte to FFh except bytes in blocks whose bit in lockMask (block index = address >> BLOCK_W) is 1. The mask is sampled at commit.
- R8: A program, sector erase or block erase whose target block is locked raises `welClear` for exactly one cycle, in the chip-select rise cycle. It never raises `busy` and leaves the memory unchanged.
- R9: A committed command raises `busy` from the cycle after the chip-select rise. `busy` stays high for more than PROG_CYC (program) or ERASE_CYC (erase) cycles, and it falls in the cycle after the single `welClear` pulse that ends the command.
- R10: While `busy` is 1, and in the final cycle of the command, `cmdStart`, `dataValid` and `csRise` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdStart | input | 1 | One-cycle pulse: a new command begins |
| cmdKind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| cmdAddr | input | ADDR_W | Target address, valid with cmdStart |
| dataValid | input | 1 | One-cycle pulse: a program data byte is complete |
| dataByte | input | 8 | Data byte, valid with dataValid |
| csRise | input | 1 | One-cycle pulse: chip select rose |
| csAligned | input | 1 | With csRise: the edge came right after a byte's last bit, with the serial clock low |
| wel | input | 1 | Current state of the write-enable latch |
| lockMask | input | 2**(ADDR_W-BLOCK_W) | Per-block write lock from the protection logic |
| rdAddr | input | ADDR_W | Read address into the array |
| rdData | output | 8 | Array byte at rdAddr, combinational |
| busy | output | 1 | Internal write cycle in progress |
| welClear | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
There are two places where functions can coincide in a single cycle. The first is buffer capture and the commit decision: the bench sends the last data byte of a program in the same cycle as the chip-select rise, then reads the page back and expects that byte to have been merged. The second is the final memory write of a cycle and the arrival of a new command. The bench raises `cmdStart` in the very cycle `welClear` is seen, and sends a new command and a chip-select rise part-way through the busy interval. It then requires that `busy` does not come back and that the array holds only the first command's result.

// File: rtl/pgmseq_pkg.sv
package pgmseq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SECTOR = 2'd1,
    OP_BLOCK  = 2'd2,
    OP_CHIP   = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_TIMER,
    S_APPLY
  } seqState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchCmd;   // capture target address, clear page buffer
    logic bufWrite;   // store dataByte at current page offset
    logic mergeByte;  // AND buffered byte into memory at walk address
    logic eraseByte;  // write FFh at walk address
  } dpStrobe_t;

endpackage

// File: rtl/pgmseq_dp.sv
module pgmseq_dp
  import pgmseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        dataByte,
  input  logic [ADDR_W-1:0] walkAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] targetAddr,
  output logic [7:0]        rdData
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MEM_BYTES  = 1 << ADDR_W;

  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [PAGE_W-1:0]     pagePtr;
  logic [7:0]            mem [MEM_BYTES];
  logic [PAGE_W-1:0]     walkOfs;

  assign walkOfs = walkAddr[PAGE_W-1:0];

  // Target address and in-page write pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetAddr <= '0;
      pagePtr    <= '0;
      bufValid   <= '0;
    end else if (stb.latchCmd) begin
      targetAddr <= cmdAddr;
      pagePtr    <= cmdAddr[PAGE_W-1:0];
      bufValid   <= '0;
    end else if (stb.bufWrite) begin
      pagePtr           <= pagePtr + 1'b1;
      bufValid[pagePtr] <= 1'b1;
    end
  end

  // Page buffer storage, no reset needed: guarded by bufValid
  always_ff @(posedge clk) begin
    if (stb.bufWrite) pageBuf[pagePtr] <= dataByte;
  end

  // Behavioural array
  always_ff @(posedge clk) begin
    if (stb.eraseByte) begin
      mem[walkAddr] <= 8'hFF;
    end else if (stb.mergeByte && bufValid[walkOfs]) begin
      mem[walkAddr] <= mem[walkAddr] & pageBuf[walkOfs];
    end
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/pgmseq_ctrl.sv
module pgmseq_ctrl
  import pgmseq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 8,
  parameter int SECTOR_W  = 9,
  parameter int BLOCK_W   = 10,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 120
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cmdStart,
  input  opKind_e                       cmdKind,
  input  logic                          dataValid,
  input  logic                          csRise,
  input  logic                          csAligned,
  input  logic                          wel,
  input  logic [(1<<(ADDR_W-BLOCK_W))-1:0] lockMask,
  input  logic [ADDR_W-1:0]             targetAddr,
  output dpStrobe_t                     stb,
  output logic [ADDR_W-1:0]             walkAddr,
  output logic                          busy,
  output logic                          welClear
);

  localparam int NUM_BLK = 1 << (ADDR_W - BLOCK_W);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0]  PROG_LOAD  = TMR_W'(PROG_CYC - 1);
  localparam logic [TMR_W-1:0]  ERASE_LOAD = TMR_W'(ERASE_CYC - 1);
  localparam logic [ADDR_W-1:0] PAGE_MASK  = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] SECT_MASK  = ADDR_W'((1 << SECTOR_W) - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK   = ADDR_W'((1 << BLOCK_W) - 1);

  seqState_e          state, nxt;
  opKind_e            kind;
  logic               dataSeen;
  logic [TMR_W-1:0]   timer;
  logic [ADDR_W-1:0]  walk, walkLast;
  logic [NUM_BLK-1:0] lockSnap;
  logic [ADDR_W-1:0]  regionMask, regionStart, regionLast;
  logic               targetLocked, commitOk, progByte;

  // Region covered by the latched command
  always_comb begin
    unique case (kind)
      OP_PROG:   regionMask = PAGE_MASK;
      OP_SECTOR: regionMask = SECT_MASK;
      OP_BLOCK:  regionMask = BLK_MASK;
      default:   regionMask = '1;
    endcase
  end

  assign regionStart  = targetAddr & ~regionMask;
  assign regionLast   = regionStart | regionMask;
  assign targetLocked = lockMask[targetAddr[ADDR_W-1:BLOCK_W]];
  assign progByte     = dataValid && (kind == OP_PROG);
  assign commitOk     = wel && csAligned &&
                        ((kind != OP_PROG) || dataSeen || dataValid);

  always_comb begin
    nxt      = state;
    stb      = '0;
    welClear = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cmdStart) begin
          stb.latchCmd = 1'b1;
          nxt          = S_LOAD;
        end
      end
      S_LOAD: begin
        if (csRise) begin
          stb.bufWrite = progByte;
          if (!commitOk) begin
            nxt = S_IDLE;
          end else if (targetLocked && (kind != OP_CHIP)) begin
            welClear = 1'b1;
            nxt      = S_IDLE;
          end else begin
            nxt = S_TIMER;
          end
        end else if (cmdStart) begin
          stb.latchCmd = 1'b1;
        end else begin
          stb.bufWrite = progByte;
        end
      end
      S_TIMER: begin
        if (timer == '0) nxt = S_APPLY;
      end
      S_APPLY: begin
        if (kind == OP_PROG) begin
          stb.mergeByte = 1'b1;
        end else if (kind == OP_CHIP) begin
          stb.eraseByte = !lockSnap[walk[ADDR_W-1:BLOCK_W]];
        end else begin
          stb.eraseByte = 1'b1;
        end
        if (walk == walkLast) begin
          welClear = 1'b1;
          nxt      = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= OP_PROG;
      dataSeen <= 1'b0;
      timer    <= '0;
      walk     <= '0;
      walkLast <= '0;
      lockSnap <= '0;
    end else begin
      state <= nxt;
      if (stb.latchCmd) begin
        kind     <= cmdKind;
        dataSeen <= 1'b0;
      end else if (stb.bufWrite) begin
        dataSeen <= 1'b1;
      end
      if (state == S_LOAD && nxt == S_TIMER) begin
        timer    <= (kind == OP_PROG) ? PROG_LOAD : ERASE_LOAD;
        walk     <= regionStart;
        walkLast <= regionLast;
        lockSnap <= lockMask;
      end else if (state == S_TIMER) begin
        timer <= timer - 1'b1;
      end else if (state == S_APPLY) begin
        walk <= walk + 1'b1;
      end
    end
  end

  assign walkAddr = walk;
  assign busy     = (state == S_TIMER) || (state == S_APPLY);

endmodule

// File: rtl/flash_write_seq.sv
module flash_write_seq
  import pgmseq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 8,
  parameter int SECTOR_W  = 9,
  parameter int BLOCK_W   = 10,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 120,
  localparam int NUM_BLK  = 1 << (ADDR_W - BLOCK_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic [1:0]         cmdKind,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic               dataValid,
  input  logic [7:0]         dataByte,
  input  logic               csRise,
  input  logic               csAligned,
  input  logic               wel,
  input  logic [NUM_BLK-1:0] lockMask,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [7:0]         rdData,
  output logic               busy,
  output logic               welClear
);

  dpStrobe_t         stb;
  logic [ADDR_W-1:0] walkAddr;
  logic [ADDR_W-1:0] targetAddr;

  pgmseq_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdKind(opKind_e'(cmdKind)),
    .dataValid(dataValid), .csRise(csRise), .csAligned(csAligned), .wel(wel),
    .lockMask(lockMask), .targetAddr(targetAddr), .stb(stb), .walkAddr(walkAddr),
    .busy(busy), .welClear(welClear)
  );

  pgmseq_dp #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .dataByte(dataByte),
    .walkAddr(walkAddr), .rdAddr(rdAddr), .targetAddr(targetAddr), .rdData(rdData)
  );

endmodule

// File: rtl/flash_write_seq_chk.sv
module flash_write_seq_chk #(
  parameter int PROG_CYC = 40
) (
  input logic clk,
  input logic rstN,
  input logic csRise,
  input logic csAligned,
  input logic wel,
  input logic busy,
  input logic welClear
);

  logic [31:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= '0;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (!busy && !welClear));

  assert_commit_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise && csAligned));

  assert_wel_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

  assert_reject_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    (welClear && !busy) |-> csRise);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    welClear |=> !welClear);

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(welClear));

  assert_min_length_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen > PROG_CYC));

endmodule

bind flash_write_seq flash_write_seq_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .csRise(csRise), .csAligned(csAligned),
  .wel(wel), .busy(busy), .welClear(welClear)
);

// File: tb/flash_write_seq_tb.sv
`timescale 1ns/1ps
module flash_write_seq_tb;

  localparam int ADDR_W = 12, PAGE_W = 8, SECTOR_W = 9, BLOCK_W = 10;
  localparam int PROG_CYC = 40, ERASE_CYC = 120;
  localparam int NUM_BLK = 1 << (ADDR_W - BLOCK_W);
  localparam int MEMN = 1 << ADDR_W;
  localparam int PAGEN = 1 << PAGE_W;

  logic clk = 0, rstN = 0;
  logic cmdStart = 0, dataValid = 0, csRise = 0, csAligned = 0, wel = 0;
  logic [1:0] cmdKind = 0;
  logic [ADDR_W-1:0] cmdAddr = 0, rdAddr = 0;
  logic [7:0] dataByte = 0, rdData;
  logic [NUM_BLK-1:0] lockMask = 0;
  logic busy, welClear;

  int nChecks = 0, nFails = 0;
  logic [7:0] model [MEMN];
  logic [7:0] txBuf [512];

  always #2.5 clk = ~clk;

  flash_write_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W),
    .BLOCK_W(BLOCK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdKind(cmdKind), .cmdAddr(cmdAddr),
    .dataValid(dataValid), .dataByte(dataByte), .csRise(csRise), .csAligned(csAligned),
    .wel(wel), .lockMask(lockMask), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .welClear(welClear));

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic compareRange(input int lo, input int hi, input string req);
    int bad = 0;
    for (int a = lo; a <= hi; a++) begin
      rdAddr = ADDR_W'(a);
      #0.2;
      if (rdData !== model[a]) begin
        if (bad == 0)
          $display("FAIL %s: addr %0h got %0h expected %0h", req, a, rdData, model[a]);
        bad++;
      end
    end
    nChecks++;
    if (bad != 0) nFails++;
  endtask

  function automatic int regionMask(input int kind);
    case (kind)
      0: return PAGEN - 1;
      1: return (1 << SECTOR_W) - 1;
      2: return (1 << BLOCK_W) - 1;
      default: return MEMN - 1;
    endcase
  endfunction

  task automatic applyModel(input int kind, input int addr, input int n);
    logic [7:0] pb [PAGEN];
    bit pv [PAGEN];
    int base, ptr;
    base = addr & ~regionMask(kind);
    if (kind == 0) begin
      for (int j = 0; j < PAGEN; j++) pv[j] = 0;
      ptr = addr % PAGEN;
      for (int i = 0; i < n; i++) begin
        pb[ptr] = txBuf[i]; pv[ptr] = 1; ptr = (ptr + 1) % PAGEN;
      end
      for (int j = 0; j < PAGEN; j++) if (pv[j]) model[base + j] = model[base + j] & pb[j];
    end else begin
      for (int a = base; a <= base + regionMask(kind); a++)
        if (kind != 3 || !lockMask[a >> BLOCK_W]) model[a] = 8'hFF;
    end
  endtask

  // Run one command; inject=1 fires extra commands during and at the end of busy (R10)
  task automatic runCmd(input int kind, input int addr, input int n, input bit aligned,
                        input bit welv, input bit collide, input bit inject, input string req);
    bit accept, reject;
    int pulses = 0, busyCyc = 0, cyc;
    bit locked;
    locked = lockMask[addr >> BLOCK_W];
    accept = welv && aligned && (kind != 0 || n > 0) && !(kind != 3 && locked);
    reject = welv && aligned && (kind != 0 || n > 0) && (kind != 3 && locked);
    cyc = (kind == 0) ? PROG_CYC : ERASE_CYC;
    @(negedge clk);
    wel = welv; cmdStart = 1; cmdKind = 2'(kind); cmdAddr = ADDR_W'(addr);
    @(negedge clk);
    cmdStart = 0;
    for (int i = 0; i < n; i++) begin
      dataValid = 1; dataByte = txBuf[i];
      if (collide && i == n - 1) begin csRise = 1; csAligned = aligned; end
      #1; if (welClear) pulses++;
      @(negedge clk);
    end
    dataValid = 0;
    if (!(collide && n > 0)) begin
      csRise = 1; csAligned = aligned;
      #1; if (welClear) pulses++;
      @(negedge clk);
    end
    csRise = 0; csAligned = 0;
    while (busy) begin
      if (inject && busyCyc == 2) begin cmdStart = 1; cmdKind = 2'd2; cmdAddr = 0; end
      if (inject && busyCyc == 3) begin cmdStart = 0; dataValid = 1; dataByte = 8'h00; end
      if (inject && busyCyc == 4) begin dataValid = 0; csRise = 1; csAligned = 1; end
      if (inject && busyCyc == 5) begin csRise = 0; csAligned = 0; end
      if (welClear) begin
        pulses++;
        if (inject) begin cmdStart = 1; cmdKind = 2'd2; cmdAddr = 0; end
      end
      busyCyc++;
      @(negedge clk);
    end
    cmdStart = 0; dataValid = 0;
    if (accept) begin
      check(busyCyc > cyc, {req, " R9 busy length"}, busyCyc, cyc + 1);
      check(pulses == 1, {req, " R9 welClear pulses"}, pulses, 1);
      applyModel(kind, addr, n);
    end else begin
      check(busyCyc == 0, {req, " no busy"}, busyCyc, 0);
      check(pulses == (reject ? 1 : 0), {req, " welClear pulses"}, pulses, reject ? 1 : 0);
    end
    if (inject) begin
      csRise = 1; csAligned = 1;
      @(negedge clk);
      csRise = 0; csAligned = 0;
      @(negedge clk);
      check(busy == 0, "R10 late command ignored", busy, 0);
    end
  endtask

  task automatic fillRandom(input int n);
    for (int i = 0; i < n; i++) txBuf[i] = 8'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < MEMN; a++) model[a] = 8'hFF;
    repeat (3) @(negedge clk);
    check(busy == 0, "R1 busy in reset", busy, 0);
    check(welClear == 0, "R1 welClear in reset", welClear, 0);
    rstN = 1;
    @(negedge clk);
    check(busy == 0 && welClear == 0, "R1 idle after reset", busy, 0);

    // R7 chip erase, nothing locked
    runCmd(3, 0, 0, 1, 1, 0, 0, "R7 chip erase");
    compareRange(0, MEMN - 1, "R7 chip erase all");

    // R3 wrap inside page: offset 250, 10 bytes
    fillRandom(10);
    runCmd(0, 12'h1FA, 10, 1, 1, 0, 0, "R3 wrap");
    compareRange(12'h000, 12'h2FF, "R3 wrap page");

    // R2 AND merge over earlier data
    fillRandom(20);
    runCmd(0, 12'h1F0, 20, 1, 1, 0, 0, "R2 merge");
    compareRange(12'h100, 12'h1FF, "R2 merge page");

    // R3 more than a page: later bytes replace earlier
    fillRandom(300);
    runCmd(0, 12'h300, 300, 1, 1, 0, 0, "R3 overflow");
    compareRange(12'h200, 12'h4FF, "R3 overflow page");

    // R2 random programs
    for (int k = 0; k < 6; k++) begin
      int pg, ofs, n;
      pg = $urandom_range(0, 15); ofs = $urandom_range(0, PAGEN - 1); n = $urandom_range(1, 40);
      fillRandom(n);
      runCmd(0, pg * PAGEN + ofs, n, 1, 1, 0, 0, "R2 random");
      compareRange(pg * PAGEN, pg * PAGEN + PAGEN - 1, "R2 random page");
    end

    // R2 last byte in the same cycle as the CE# rise
    fillRandom(5);
    runCmd(0, 12'h510, 5, 1, 1, 1, 0, "R2 collide");
    compareRange(12'h500, 12'h5FF, "R2 collide page");

    // R4 misaligned edge and program without data
    fillRandom(8);
    runCmd(0, 12'h600, 8, 0, 1, 0, 0, "R4 misaligned");
    runCmd(0, 12'h600, 0, 1, 1, 0, 0, "R4 no data");
    runCmd(1, 12'h600, 0, 0, 1, 0, 0, "R4 misaligned erase");
    compareRange(12'h000, 12'h7FF, "R4 unchanged");

    // R5 write enable clear
    fillRandom(8);
    runCmd(0, 12'h000, 8, 1, 0, 0, 0, "R5 program");
    runCmd(2, 12'h000, 0, 1, 0, 0, 0, "R5 erase");
    compareRange(12'h000, 12'h3FF, "R5 unchanged");

    // R8 locked target
    lockMask = 4'b0001;
    fillRandom(4);
    runCmd(0, 12'h020, 4, 1, 1, 0, 0, "R8 locked program");
    runCmd(1, 12'h020, 0, 1, 1, 0, 0, "R8 locked sector");
    compareRange(12'h000, 12'h3FF, "R8 unchanged");
    lockMask = 0;

    // R6 sector and block erase
    runCmd(1, 12'h3A5, 0, 1, 1, 0, 0, "R6 sector");
    compareRange(0, MEMN - 1, "R6 sector region");
    fillRandom(16);
    runCmd(0, 12'hA40, 16, 1, 1, 0, 0, "R6 setup");
    runCmd(2, 12'h812, 0, 1, 1, 0, 0, "R6 block");
    compareRange(0, MEMN - 1, "R6 block region");

    // R10 commands during and at the end of busy
    fillRandom(12);
    runCmd(0, 12'h0C0, 12, 1, 1, 0, 1, "R10 inject");
    compareRange(0, MEMN - 1, "R10 only first command");

    // R7 chip erase with blocks 0 and 2 locked
    for (int b = 0; b < NUM_BLK; b++) begin
      fillRandom(6);
      runCmd(0, b * (1 << BLOCK_W) + 12'h44, 6, 1, 1, 0, 0, "R7 setup");
    end
    lockMask = 4'b0101;
    runCmd(3, 0, 0, 1, 1, 0, 0, "R7 partial chip");
    compareRange(0, MEMN - 1, "R7 locked blocks kept");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule